// File: doc/BRIEF.md
# System Power Mode Sequencer

This block steers a system-on-chip through its power modes: Active, CPU Sleep, Deep Sleep, Deep Sleep RAM and Hibernate. When the main CPU signals idle, the sequencer reads a programmable idle-mode setting and a deep-sleep lock held by busy peripherals. From these it picks light sleep, one of the two deep modes, or no change. A deep mode is entered only after both the main CPU and the radio CPU report that they are ready for deep sleep. A separate request puts the chip into Hibernate.

The block owns three power-domain policy units: main logic, CPU subsystem and SRAM. Each deep mode writes its own retention pattern into them. The block also lowers the core-voltage select code and holds the I/O freeze line while the chip hibernates. Each mode has its own set of wake sources. The exit latency is counted in ticks of a 32.768 kHz enable. On return to Active the block reports how software must boot: resume, warm boot or cold boot. A wake event that arrives while a deep entry is still pending cancels the entry. Status outputs show the current mode, the last boot type and the wake sources that caused the last wake.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block reports mode Active (cur_mode 0). All three domains are ON (code 0), vcore_sel is the 1.1 V code 2 when ulp_sel is 0, boot_type is cold (2), and io_freeze and wake_done are low.
- R2: An idle_req pulse in Active picks a target from idle_cfg: 0 stays in Active, 1 goes to CPU Sleep (mode 1), 2 goes to Deep Sleep (mode 2) and 3 goes to Deep Sleep RAM (mode 3). While ds_lock is high, idle_cfg 2 or 3 leads to CPU Sleep instead.
- R3: A deep target first puts the block in the entering state (mode 5). The deep mode is entered only in a cycle in which both main_ds_rdy and radio_ds_rdy are high.
- R4: Domain codes are ON=0, full retention=1, memory retention=2 and OFF=3. In Deep Sleep the domains are main=1, CPU=1, SRAM=2. In Deep Sleep RAM they are main=2, CPU=3, SRAM=2. In Hibernate all three are 3. In Active and Sleep all three are 0.
- R5: Main accepts every code, the CPU domain rejects code 2, and the SRAM domain rejects code 1. A software write (pol_wr with pol_sel 0 main, 1 CPU, 2 SRAM) takes effect only in Active. An illegal code, or pol_sel 3, raises pol_err for one cycle and leaves every domain unchanged. A write made outside Active is ignored.
- R6: vcore_sel is 0 (0.9 V) in Deep Sleep, Deep Sleep RAM and Hibernate. In every other mode it is 2 (1.1 V) when ulp_sel is 0 and 1 (1.0 V) when ulp_sel is 1.
- R7: wake_src bits: 0 serial block 0, 1 watchdog, 2 RTC, 3 key scan, 4 radio event, 5 wake pin 0, 6 wake pin 1. Sleep wakes on any bit. The deep modes and the entering state wake on bits 0 to 4. Hibernate wakes only on bits 1, 2, 5 and 6. Any other bit has no effect.
- R8: A wake from a deep mode or Hibernate moves the block to exiting (mode 6). It returns to Active one cycle after the Nth lf_tick of the exit. N is DS_LAT_TICKS, DSRAM_LAT_TICKS or HIB_LAT_TICKS, depending on the mode left. wake_done is high for exactly one cycle, the one in which Active is reached.
- R9: On return to Active, boot_type is resume (0) after Sleep or Deep Sleep, warm (1) after Deep Sleep RAM, and cold (2) after Hibernate.
- R10: A wake source from bits 0 to 4 during the entering state cancels the entry. The block returns to Active in the next cycle with boot_type resume and a wake_done pulse.
- R11: io_freeze is high during Hibernate and throughout the exit from it. It falls when Active is reached.
- R12: A sw_rst pulse returns the block to Active from any mode on the next cycle, with all domains ON and boot_type cold.
- R13: last_wake holds the wake_src bits, masked by the mode's wake set, that ended the most recent sleep or cancelled entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| lf_tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| sw_rst | input | 1 | Software reset request |
| idle_req | input | 1 | Main CPU idle request pulse |
| hib_req | input | 1 | Hibernate request pulse |
| idle_cfg | input | 2 | Idle mode setting: 0 Active, 1 Sleep, 2 Deep Sleep, 3 Deep Sleep RAM |
| ds_lock | input | 1 | Deep-sleep lock held by a busy peripheral |
| ulp_sel | input | 1 | Active profile: 0 low power (1.1 V), 1 ultra-low power (1.0 V) |
| main_ds_rdy | input | 1 | Main CPU ready for deep sleep |
| radio_ds_rdy | input | 1 | Radio CPU ready for deep sleep |
| wake_src | input | 7 | Wake source lines (bit map in R7) |
| pol_wr | input | 1 | Software domain policy write strobe |
| pol_sel | input | 2 | Domain selected by the write |
| pol_state | input | 2 | Domain code requested by the write |
| dom_main | output | 2 | Main domain policy state |
| dom_cpu | output | 2 | CPU subsystem domain policy state |
| dom_sram | output | 2 | SRAM domain policy state |
| vcore_sel | output | 2 | Core voltage select code |
| io_freeze | output | 1 | I/O state freeze |
| wake_done | output | 1 | Pulse when Active is reached after a wake |
| pol_err | output | 1 | Illegal policy request flag |
| cur_mode | output | 3 | Current mode: 0 Active, 1 Sleep, 2 DS, 3 DS RAM, 4 Hibernate, 5 entering, 6 exiting |
| boot_type | output | 2 | Last boot type: 0 resume, 1 warm, 2 cold |
| last_wake | output | 7 | Masked wake sources of the last wake |

## Verification
The bench builds the sequencer with short exit windows of 2, 4 and 6 ticks for Deep Sleep, Deep Sleep RAM and Hibernate. With these values every tick of each window can be stepped by hand. The bench confirms that the block stays in the exiting state up to the last tick and reaches Active exactly one cycle after it. The bench drives the low-frequency tick itself, not from a free-running divider. This keeps each window's length exact and lets the bench leave the block in a deep mode for as long as it needs to test the wake masks.

// File: rtl/pms_pkg.sv
package pms_pkg;

    localparam int WAKE_W = 7;
    localparam int NUM_DOM = 3;

    typedef enum logic [2:0] {
        M_ACTIVE  = 3'd0,
        M_SLEEP   = 3'd1,
        M_DEEP    = 3'd2,
        M_DEEPRAM = 3'd3,
        M_HIBER   = 3'd4,
        M_ENTER   = 3'd5,
        M_EXIT    = 3'd6
    } pm_state_e;

    typedef enum logic [1:0] {
        PD_ON       = 2'd0,
        PD_FULL_RET = 2'd1,
        PD_MEM_RET  = 2'd2,
        PD_OFF      = 2'd3
    } pd_state_e;

    typedef enum logic [1:0] {
        BT_RESUME = 2'd0,
        BT_WARM   = 2'd1,
        BT_COLD   = 2'd2
    } boot_e;

    typedef struct packed {
        pd_state_e main_d;
        pd_state_e cpu_d;
        pd_state_e sram_d;
    } pd_pattern_t;

    localparam logic [1:0] VC_0V9 = 2'd0;
    localparam logic [1:0] VC_1V0 = 2'd1;
    localparam logic [1:0] VC_1V1 = 2'd2;

    localparam logic [WAKE_W-1:0] MASK_ANY  = 7'h7F;
    localparam logic [WAKE_W-1:0] MASK_DEEP = 7'h1F;
    localparam logic [WAKE_W-1:0] MASK_HIB  = 7'h66;

    function automatic logic [3:0] legal_of(input int dom);
        case (dom)
            0:       return 4'b1111;
            1:       return 4'b1011;
            default: return 4'b1101;
        endcase
    endfunction

    function automatic pd_pattern_t pattern_for(input pm_state_e m);
        case (m)
            M_DEEP:    return '{PD_FULL_RET, PD_FULL_RET, PD_MEM_RET};
            M_DEEPRAM: return '{PD_MEM_RET, PD_OFF, PD_MEM_RET};
            M_HIBER:   return '{PD_OFF, PD_OFF, PD_OFF};
            default:   return '{PD_ON, PD_ON, PD_ON};
        endcase
    endfunction

    function automatic logic [WAKE_W-1:0] wake_mask(input pm_state_e m);
        case (m)
            M_SLEEP:                    return MASK_ANY;
            M_DEEP, M_DEEPRAM, M_ENTER: return MASK_DEEP;
            M_HIBER:                    return MASK_HIB;
            default:                    return '0;
        endcase
    endfunction

    function automatic boot_e boot_for(input pm_state_e src);
        case (src)
            M_DEEPRAM: return BT_WARM;
            M_HIBER:   return BT_COLD;
            default:   return BT_RESUME;
        endcase
    endfunction

endpackage

// File: rtl/pms_domain.sv
module pms_domain
    import pms_pkg::*;
#(
    parameter logic [3:0] LEGAL = 4'b1111
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      seq_set,
    input  pd_state_e seq_state,
    input  logic      sw_wr,
    input  logic [1:0] sw_state,
    output pd_state_e state,
    output logic      err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PD_ON;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (seq_set) begin
                if (LEGAL[seq_state]) state <= seq_state;
                else                  err   <= 1'b1;
            end else if (sw_wr) begin
                if (LEGAL[sw_state]) state <= pd_state_e'(sw_state);
                else                 err   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pms_wake_gate.sv
module pms_wake_gate
    import pms_pkg::*;
(
    input  pm_state_e          st,
    input  logic [WAKE_W-1:0]  src,
    output logic [WAKE_W-1:0]  hits,
    output logic               any
);
    assign hits = src & wake_mask(st);
    assign any  = |hits;
endmodule

// File: rtl/pms_exit_timer.sv
module pms_exit_timer #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    input  logic [CW-1:0] lat,
    output logic          done
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lat_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                lat_q  <= lat;
            end else if (busy_q && tick) begin
                if (cnt_q == lat_q - 1'b1) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int DS_LAT_TICKS    = 2,
    parameter int DSRAM_LAT_TICKS = 27,
    parameter int HIB_LAT_TICKS   = 66
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lf_tick,
    input  logic              sw_rst,
    input  logic              idle_req,
    input  logic              hib_req,
    input  logic [1:0]        idle_cfg,
    input  logic              ds_lock,
    input  logic              ulp_sel,
    input  logic              main_ds_rdy,
    input  logic              radio_ds_rdy,
    input  logic [6:0]        wake_src,
    input  logic              pol_wr,
    input  logic [1:0]        pol_sel,
    input  logic [1:0]        pol_state,
    output logic [1:0]        dom_main,
    output logic [1:0]        dom_cpu,
    output logic [1:0]        dom_sram,
    output logic [1:0]        vcore_sel,
    output logic              io_freeze,
    output logic              wake_done,
    output logic              pol_err,
    output logic [2:0]        cur_mode,
    output logic [1:0]        boot_type,
    output logic [6:0]        last_wake
);
    localparam int LAT_MAX_A = (DS_LAT_TICKS > DSRAM_LAT_TICKS) ? DS_LAT_TICKS : DSRAM_LAT_TICKS;
    localparam int LAT_MAX   = (LAT_MAX_A > HIB_LAT_TICKS) ? LAT_MAX_A : HIB_LAT_TICKS;
    localparam int CW        = $clog2(LAT_MAX + 1);

    pm_state_e state_q, nxt;
    pm_state_e tgt_q, src_q;
    boot_e     boot_q, fin_boot;
    logic [WAKE_W-1:0] last_wake_q;
    logic      wake_done_q, bad_sel_q;

    logic              seq_set, finish, tmr_start, tmr_done;
    pd_pattern_t       pat;
    pd_state_e         seq_st [NUM_DOM];
    pd_state_e         dom_q  [NUM_DOM];
    logic [NUM_DOM-1:0] dom_err;
    logic [CW-1:0]     lat_sel;
    logic [WAKE_W-1:0] hits;
    logic              hit;
    pm_state_e         entry_tgt;
    logic              both_rdy;

    pms_wake_gate u_gate (
        .st   (state_q),
        .src  (wake_src),
        .hits (hits),
        .any  (hit)
    );

    pms_exit_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst || sw_rst),
        .start (tmr_start),
        .tick  (lf_tick),
        .lat   (lat_sel),
        .done  (tmr_done)
    );

    assign both_rdy = main_ds_rdy && radio_ds_rdy;

    always_comb begin
        if (idle_cfg == 2'd1 || ds_lock) entry_tgt = M_SLEEP;
        else if (idle_cfg == 2'd2)      entry_tgt = M_DEEP;
        else                            entry_tgt = M_DEEPRAM;
    end

    always_comb begin
        case (state_q)
            M_DEEP:    lat_sel = CW'(DS_LAT_TICKS);
            M_DEEPRAM: lat_sel = CW'(DSRAM_LAT_TICKS);
            default:   lat_sel = CW'(HIB_LAT_TICKS);
        endcase
    end

    always_comb begin
        nxt       = state_q;
        seq_set   = 1'b0;
        pat       = pattern_for(M_ACTIVE);
        tmr_start = 1'b0;
        finish    = 1'b0;
        fin_boot  = BT_RESUME;
        case (state_q)
            M_ACTIVE: begin
                if (hib_req) begin
                    nxt     = M_HIBER;
                    seq_set = 1'b1;
                    pat     = pattern_for(M_HIBER);
                end else if (idle_req && idle_cfg != 2'd0) begin
                    nxt = (entry_tgt == M_SLEEP) ? M_SLEEP : M_ENTER;
                end
            end
            M_SLEEP: begin
                if (hit) finish = 1'b1;
            end
            M_ENTER: begin
                if (hit) begin
                    finish = 1'b1;
                end else if (both_rdy) begin
                    nxt     = tgt_q;
                    seq_set = 1'b1;
                    pat     = pattern_for(tgt_q);
                end
            end
            M_DEEP, M_DEEPRAM, M_HIBER: begin
                if (hit) begin
                    nxt       = M_EXIT;
                    tmr_start = 1'b1;
                end
            end
            M_EXIT: begin
                if (tmr_done) begin
                    finish   = 1'b1;
                    fin_boot = boot_for(src_q);
                end
            end
            default: nxt = M_ACTIVE;
        endcase
        if (finish) begin
            nxt     = M_ACTIVE;
            seq_set = 1'b1;
            pat     = pattern_for(M_ACTIVE);
        end
        if (sw_rst) begin
            nxt      = M_ACTIVE;
            seq_set  = 1'b1;
            pat      = pattern_for(M_ACTIVE);
            finish   = 1'b0;
            fin_boot = BT_COLD;
        end
    end

    always_comb begin
        seq_st[0] = pat.main_d;
        seq_st[1] = pat.cpu_d;
        seq_st[2] = pat.sram_d;
    end

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        pms_domain #(.LEGAL(legal_of(g))) u_dom (
            .clk       (clk),
            .rst       (rst),
            .seq_set   (seq_set),
            .seq_state (seq_st[g]),
            .sw_wr     (pol_wr && state_q == M_ACTIVE && pol_sel == 2'(g) && !seq_set),
            .sw_state  (pol_state),
            .state     (dom_q[g]),
            .err       (dom_err[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= M_ACTIVE;
            tgt_q       <= M_DEEP;
            src_q       <= M_DEEP;
            boot_q      <= BT_COLD;
            last_wake_q <= '0;
            wake_done_q <= 1'b0;
            bad_sel_q   <= 1'b0;
        end else begin
            state_q     <= nxt;
            wake_done_q <= finish;
            bad_sel_q   <= pol_wr && state_q == M_ACTIVE && pol_sel == 2'd3 && !seq_set;
            if (state_q == M_ACTIVE && nxt == M_ENTER) tgt_q <= entry_tgt;
            if (tmr_start) src_q <= state_q;
            if (hit && !sw_rst) last_wake_q <= hits;
            if (finish || sw_rst) boot_q <= fin_boot;
        end
    end

    assign dom_main  = dom_q[0];
    assign dom_cpu   = dom_q[1];
    assign dom_sram  = dom_q[2];
    assign cur_mode  = state_q;
    assign boot_type = boot_q;
    assign last_wake = last_wake_q;
    assign wake_done = wake_done_q;
    assign pol_err   = (|dom_err) || bad_sel_q;
    assign io_freeze = (state_q == M_HIBER) || (state_q == M_EXIT && src_q == M_HIBER);
    assign vcore_sel = (state_q == M_DEEP || state_q == M_DEEPRAM || state_q == M_HIBER) ? VC_0V9 :
                       (ulp_sel ? VC_1V0 : VC_1V1);

endmodule

// File: rtl/pms_checker.sv
module pms_checker (
    input logic       clk,
    input logic       rst,
    input logic       main_ds_rdy,
    input logic       radio_ds_rdy,
    input logic [1:0] dom_main,
    input logic [1:0] dom_cpu,
    input logic [1:0] dom_sram,
    input logic [1:0] vcore_sel,
    input logic       io_freeze,
    input logic       wake_done,
    input logic [2:0] cur_mode
);
    assert_cpu_legal_R5: assert property (@(posedge clk) disable iff (rst)
        dom_cpu != 2'd2 && dom_sram != 2'd1);

    assert_hib_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 3'd4 |-> io_freeze);

    assert_deep_vcore_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd2 || cur_mode == 3'd3) |-> vcore_sel == 2'd0);

    assert_deep_needs_rdy_R3: assert property (@(posedge clk) disable iff (rst)
        ((cur_mode == 3'd2 || cur_mode == 3'd3) && $past(cur_mode) == 3'd5)
        |-> $past(main_ds_rdy && radio_ds_rdy));

    assert_ds_pattern_R4: assert property (@(posedge clk) disable iff (rst)
        cur_mode == 3'd2 |-> (dom_main == 2'd1 && dom_cpu == 2'd1 && dom_sram == 2'd2));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> !wake_done);

    assert_done_active_R8: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> cur_mode == 3'd0);
endmodule

bind pwr_mode_seq pms_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .main_ds_rdy  (main_ds_rdy),
    .radio_ds_rdy (radio_ds_rdy),
    .dom_main     (dom_main),
    .dom_cpu      (dom_cpu),
    .dom_sram     (dom_sram),
    .vcore_sel    (vcore_sel),
    .io_freeze    (io_freeze),
    .wake_done    (wake_done),
    .cur_mode     (cur_mode)
);

// File: tb/pwr_mode_seq_tb_top.sv
module pwr_mode_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lf_tick = 0, sw_rst = 0, idle_req = 0, hib_req = 0;
    logic [1:0] idle_cfg = 0;
    logic ds_lock = 0, ulp_sel = 0, main_ds_rdy = 1, radio_ds_rdy = 1;
    logic [6:0] wake_src = 0;
    logic pol_wr = 0;
    logic [1:0] pol_sel = 0, pol_state = 0;
    logic [1:0] dom_main, dom_cpu, dom_sram, vcore_sel, boot_type;
    logic io_freeze, wake_done, pol_err;
    logic [2:0] cur_mode;
    logic [6:0] last_wake;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pwr_mode_seq #(.DS_LAT_TICKS(2), .DSRAM_LAT_TICKS(4), .HIB_LAT_TICKS(6)) dut_i (
        .clk(clk), .rst(rst), .lf_tick(lf_tick), .sw_rst(sw_rst), .idle_req(idle_req),
        .hib_req(hib_req), .idle_cfg(idle_cfg), .ds_lock(ds_lock), .ulp_sel(ulp_sel),
        .main_ds_rdy(main_ds_rdy), .radio_ds_rdy(radio_ds_rdy), .wake_src(wake_src),
        .pol_wr(pol_wr), .pol_sel(pol_sel), .pol_state(pol_state),
        .dom_main(dom_main), .dom_cpu(dom_cpu), .dom_sram(dom_sram), .vcore_sel(vcore_sel),
        .io_freeze(io_freeze), .wake_done(wake_done), .pol_err(pol_err), .cur_mode(cur_mode),
        .boot_type(boot_type), .last_wake(last_wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_idle();
        idle_req = 1; @(negedge clk); idle_req = 0;
    endtask

    task automatic pulse_wake(input logic [6:0] v);
        wake_src = v; @(negedge clk); wake_src = 0;
    endtask

    task automatic pulse_tick();
        lf_tick = 1; @(negedge clk); lf_tick = 0;
    endtask

    task automatic pol_write(input logic [1:0] s, input logic [1:0] v);
        pol_sel = s; pol_state = v; pol_wr = 1; @(negedge clk); pol_wr = 0;
    endtask

    task automatic t_reset();
        chk("R1 mode", cur_mode, 0);
        chk("R1 main", dom_main, 0);
        chk("R1 cpu", dom_cpu, 0);
        chk("R1 sram", dom_sram, 0);
        chk("R1 vcore", vcore_sel, 2);
        chk("R1 boot", boot_type, 2);
        chk("R1 freeze", io_freeze, 0);
        chk("R1 wake_done", wake_done, 0);
    endtask

    task automatic t_sleep();
        idle_cfg = 0; pulse_idle(); cyc(2);
        chk("R2 cfg0 stays active", cur_mode, 0);
        idle_cfg = 1; pulse_idle(); cyc(2);
        chk("R2 cfg1 sleep", cur_mode, 1);
        chk("R6 sleep vcore", vcore_sel, 2);
        chk("R4 sleep sram on", dom_sram, 0);
        pulse_wake(7'h20);
        chk("R7 sleep any source", cur_mode, 0);
        chk("R8 wake_done sleep", wake_done, 1);
        chk("R9 boot resume sleep", boot_type, 0);
        chk("R13 last wake pin", last_wake, 7'h20);
        @(negedge clk);
        chk("R8 wake_done one cycle", wake_done, 0);
        idle_cfg = 2; ds_lock = 1; pulse_idle(); cyc(2);
        chk("R2 lock forces sleep", cur_mode, 1);
        ds_lock = 0; pulse_wake(7'h01); cyc(1);
    endtask

    task automatic t_deep();
        radio_ds_rdy = 0; idle_cfg = 2; pulse_idle(); cyc(4);
        chk("R3 waits for radio", cur_mode, 5);
        radio_ds_rdy = 1; cyc(2);
        chk("R3 enters deep", cur_mode, 2);
        chk("R4 ds main", dom_main, 1);
        chk("R4 ds cpu", dom_cpu, 1);
        chk("R4 ds sram", dom_sram, 2);
        chk("R6 ds vcore", vcore_sel, 0);
        pulse_wake(7'h20); cyc(2);
        chk("R7 ds ignores pin", cur_mode, 2);
        pulse_wake(7'h04); cyc(2);
        chk("R8 exiting", cur_mode, 6);
        pulse_tick(); cyc(3);
        chk("R8 still exiting", cur_mode, 6);
        pulse_tick();
        chk("R8 not yet active", cur_mode, 6);
        @(negedge clk);
        chk("R8 ds active", cur_mode, 0);
        chk("R8 ds wake_done", wake_done, 1);
        chk("R9 ds resume", boot_type, 0);
        chk("R13 rtc recorded", last_wake, 7'h04);
        chk("R4 active main on", dom_main, 0);
        cyc(1);
    endtask

    task automatic t_dsram();
        idle_cfg = 3; pulse_idle(); cyc(3);
        chk("R2 cfg3 dsram", cur_mode, 3);
        chk("R4 dsram main", dom_main, 2);
        chk("R4 dsram cpu", dom_cpu, 3);
        chk("R4 dsram sram", dom_sram, 2);
        pulse_wake(7'h10); cyc(1);
        for (int i = 0; i < 3; i++) begin pulse_tick(); cyc(1); end
        chk("R8 dsram window", cur_mode, 6);
        pulse_tick(); @(negedge clk);
        chk("R8 dsram active", cur_mode, 0);
        chk("R9 dsram warm", boot_type, 1);
        cyc(1);
    endtask

    task automatic t_abort();
        radio_ds_rdy = 0; idle_cfg = 2; pulse_idle(); cyc(2);
        chk("R3 entering", cur_mode, 5);
        pulse_wake(7'h08);
        chk("R10 abort active", cur_mode, 0);
        chk("R10 abort wake_done", wake_done, 1);
        chk("R10 abort resume", boot_type, 0);
        chk("R13 keyscan recorded", last_wake, 7'h08);
        radio_ds_rdy = 1; cyc(1);
    endtask

    task automatic t_hib();
        hib_req = 1; @(negedge clk); hib_req = 0; cyc(1);
        chk("R2 hib mode", cur_mode, 4);
        chk("R4 hib main off", dom_main, 3);
        chk("R4 hib sram off", dom_sram, 3);
        chk("R11 freeze in hib", io_freeze, 1);
        pulse_wake(7'h01); cyc(2);
        chk("R7 hib ignores serial", cur_mode, 4);
        pulse_wake(7'h40); cyc(1);
        chk("R11 freeze during exit", io_freeze, 1);
        for (int i = 0; i < 5; i++) begin pulse_tick(); cyc(1); end
        chk("R8 hib window", cur_mode, 6);
        pulse_tick(); @(negedge clk);
        chk("R8 hib active", cur_mode, 0);
        chk("R9 hib cold", boot_type, 2);
        chk("R11 freeze released", io_freeze, 0);
        cyc(1);
    endtask

    task automatic t_policy();
        pol_write(2'd1, 2'd2);
        chk("R5 cpu illegal flagged", pol_err, 1);
        chk("R5 cpu unchanged", dom_cpu, 0);
        pol_write(2'd2, 2'd1);
        chk("R5 sram illegal flagged", pol_err, 1);
        chk("R5 sram unchanged", dom_sram, 0);
        pol_write(2'd2, 2'd3);
        chk("R5 sram legal", dom_sram, 3);
        chk("R5 no error", pol_err, 0);
        pol_write(2'd3, 2'd0);
        chk("R5 bad select", pol_err, 1);
        pol_write(2'd2, 2'd0);
        idle_cfg = 1; pulse_idle(); cyc(1);
        pol_write(2'd0, 2'd3); cyc(1);
        chk("R5 ignored in sleep", dom_main, 0);
        pulse_wake(7'h02); cyc(1);
    endtask

    task automatic t_ulp_swrst();
        ulp_sel = 1; cyc(1);
        chk("R6 ulp code", vcore_sel, 1);
        ulp_sel = 0;
        idle_cfg = 2; pulse_idle(); cyc(3);
        chk("R12 setup deep", cur_mode, 2);
        sw_rst = 1; @(negedge clk); sw_rst = 0;
        chk("R12 active", cur_mode, 0);
        chk("R12 cold", boot_type, 2);
        chk("R12 domains on", dom_cpu, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 0;
        cyc(1);
        t_reset();
        t_sleep();
        t_deep();
        t_dsram();
        t_abort();
        t_hib();
        t_policy();
        t_ulp_swrst();
        cyc(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule